// File: doc/BRIEF.md
# Serial ADC Host Interface Logic

This block is the digital side of a multi-channel successive-approximation converter as seen through its serial host port. A host pulls chip select low and toggles an I/O clock twelve times. During the first eight clocks it shifts in a command byte, most significant bit first. Throughout the frame it receives the result of the conversion that the previous frame requested, also most significant bit first. The upper command bits pick the input channel. The channel address reaches the analog multiplexer partway through the command byte. A sample window tells the capacitor array when to track the chosen input.

After the last falling I/O clock edge, the block hands over to an internal successive-approximation engine, and the end-of-conversion flag drops. The engine resolves one bit per fixed number of system clocks, asking a behavioural comparator whether the selected input code is at least the trial code. When the last bit is decided, the result is stored for the next frame and the flag rises again. Chip select, the I/O clock and the data input all come from outside and are resynchronised to the fast system clock. All edge timing is derived from that synchronised copy.

Top module: `adc_host_if`

## Requirements
- R1: While reset is high and after it is released, eoc is 1, dout_en is 0, sample_win is 0, mux_addr is 0 and cmd_word is 0.
- R2: The command is taken from din on the first eight rising I/O clock edges of a frame, first bit into cmd_word bit 7. cmd_word updates after the eighth rising edge. din on rising edges nine to twelve has no effect on cmd_word.
- R3: mux_addr takes command bits 7:4 after the fourth rising I/O clock edge. After the third rising edge it still holds its earlier value.
- R4: sample_win goes high after the fourth falling I/O clock edge of a frame and goes low after the twelfth.
- R5: dout shows bit 11 of the stored result once chip select is low and before any I/O clock. Each of the first eleven falling edges advances dout to the next lower bit. dout never changes across a rising edge.
- R6: dout_en is 1 while cs_n is low and 0 while it is high.
- R7: The twelfth falling edge starts a conversion. eoc is 0 from a few system clocks after that edge until RES_BITS*CYC_PER_BIT system clocks after the start, and then returns to 1.
- R8: A finished conversion stores the ain_code presented for the selected channel, including codes 0x000 and 0xFFF.
- R9: If cs_n rises before the twelfth falling edge, the frame is dropped. No conversion starts, eoc stays 1, sample_win goes low, cmd_word keeps its value and the stored result is unchanged.
- R10: The first frame after reset returns 0x000 on dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the host signals |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select from the host, active low |
| io_clk | input | 1 | Host I/O clock |
| din | input | 1 | Serial command input |
| ain_code | input | RES_BITS | Digital stand-in for the selected analog input level |
| dout | output | 1 | Serial result output, MSB first |
| dout_en | output | 1 | Output drive enable; low means the data line is released |
| sample_win | output | 1 | Sample window to the capacitor array |
| eoc | output | 1 | End of conversion, low while converting |
| mux_addr | output | ADDR_BITS | Selected input channel |
| cmd_word | output | CMD_BITS | Last complete command byte |

## Verification
The bench keeps the default parameters: RES_BITS 12, CMD_BITS 8, ADDR_BITS 4, CYC_PER_BIT 4 and SYNC_STAGES 2. With four system clocks per bit, a conversion lasts 48 cycles, short enough to chain many frames and still measure the busy interval. The 4-bit address reaches channels 0 and 15, which the bench's input model maps to the all-zeros and all-ones codes. Each I/O clock phase is eight system clocks, so every edge clears the two-stage synchroniser before the next edge arrives. That lets the bench check the address, the sample window and dout after individual rising and falling edges.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;
  typedef enum logic {SAR_IDLE = 1'b0, SAR_RUN = 1'b1} sar_state_e;
endpackage

// File: rtl/adc_sync.sv
`timescale 1ns/1ps
module adc_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
module adc_serial_port #(
  parameter int RES_BITS  = 12,
  parameter int CMD_BITS  = 8,
  parameter int ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_act,
  input  logic                 io_lvl,
  input  logic                 din_s,
  input  logic [RES_BITS-1:0]  prev_result,
  output logic [ADDR_BITS-1:0] mux_addr,
  output logic [CMD_BITS-1:0]  cmd_word,
  output logic                 sample_win,
  output logic                 conv_start,
  output logic                 dout,
  output logic                 dout_en
);
  localparam int FRAME_CLKS = RES_BITS;
  localparam int CW = $clog2(FRAME_CLKS + 1);

  logic              io_prev, cs_prev;
  logic              io_rise, io_fall, frame_start;
  logic [CW-1:0]     rise_cnt, fall_cnt;
  logic [CMD_BITS-2:0] cmd_sr;
  logic [RES_BITS-1:0] out_sr;
  logic              done;

  assign io_rise     = io_lvl & ~io_prev;
  assign io_fall     = ~io_lvl & io_prev;
  assign frame_start = cs_act & ~cs_prev;
  assign dout        = out_sr[RES_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      io_prev    <= 1'b0;
      cs_prev    <= 1'b0;
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      cmd_sr     <= '0;
      cmd_word   <= '0;
      mux_addr   <= '0;
      out_sr     <= '0;
      done       <= 1'b0;
      sample_win <= 1'b0;
      conv_start <= 1'b0;
      dout_en    <= 1'b0;
    end else begin
      io_prev    <= io_lvl;
      cs_prev    <= cs_act;
      conv_start <= 1'b0;
      dout_en    <= cs_act;
      if (!cs_act) begin
        rise_cnt   <= '0;
        fall_cnt   <= '0;
        done       <= 1'b0;
        sample_win <= 1'b0;
      end else if (frame_start) begin
        out_sr     <= prev_result;
        rise_cnt   <= '0;
        fall_cnt   <= '0;
        done       <= 1'b0;
        sample_win <= 1'b0;
      end else if (!done) begin
        if (io_rise && rise_cnt < CW'(CMD_BITS)) begin
          cmd_sr   <= {cmd_sr[CMD_BITS-3:0], din_s};
          rise_cnt <= rise_cnt + 1'b1;
          if (rise_cnt == CW'(ADDR_BITS - 1))
            mux_addr <= {cmd_sr[ADDR_BITS-2:0], din_s};
          if (rise_cnt == CW'(CMD_BITS - 1))
            cmd_word <= {cmd_sr, din_s};
        end
        if (io_fall) begin
          fall_cnt <= fall_cnt + 1'b1;
          if (fall_cnt == CW'(FRAME_CLKS - 1)) begin
            sample_win <= 1'b0;
            conv_start <= 1'b1;
            done       <= 1'b1;
          end else begin
            out_sr <= {out_sr[RES_BITS-2:0], 1'b0};
            if (fall_cnt == CW'(ADDR_BITS - 1)) sample_win <= 1'b1;
          end
        end
      end
    end
  end

  // R2: never more command bits than the byte holds
  a_r2_cmd_count_bound: assert property (@(posedge clk) disable iff (rst)
    rise_cnt <= CW'(CMD_BITS));

  // R4: window only spans the 4th..last falling edges
  a_r4_win_span: assert property (@(posedge clk) disable iff (rst)
    sample_win |-> (fall_cnt >= CW'(ADDR_BITS) && fall_cnt < CW'(FRAME_CLKS)));

  // R5: output bit moves only on a falling edge or at frame start
  a_r5_dout_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!io_fall && !frame_start) |=> $stable(dout));

  // R7: a conversion request follows the last falling edge
  a_r7_start_last_fall: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ($past(io_fall) && $past(fall_cnt) == CW'(FRAME_CLKS - 1)));

  // R9: deselect clears the frame state
  a_r9_deselect_clears: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (!sample_win && rise_cnt == '0 && fall_cnt == '0));
endmodule

// File: rtl/adc_cmp_model.sv
`timescale 1ns/1ps
module adc_cmp_model #(
  parameter int RES_BITS = 12
) (
  input  logic [RES_BITS-1:0] ain_code,
  input  logic [RES_BITS-1:0] trial,
  output logic                keep
);
  assign keep = (ain_code >= trial);
endmodule

// File: rtl/adc_sar_engine.sv
`timescale 1ns/1ps
module adc_sar_engine
  import adc_host_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int CYC_PER_BIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                cmp_keep,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] result,
  output logic                eoc
);
  localparam int BW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
  localparam int KW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;

  sar_state_e          state;
  logic [BW-1:0]       bit_idx;
  logic [KW-1:0]       cyc;
  logic [RES_BITS-1:0] resolved;

  always_comb
    resolved = cmp_keep ? trial : (trial & ~(RES_BITS'(1) << bit_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SAR_IDLE;
      bit_idx <= '0;
      cyc     <= '0;
      trial   <= '0;
      result  <= '0;
      eoc     <= 1'b1;
    end else begin
      case (state)
        SAR_IDLE: begin
          if (start) begin
            state   <= SAR_RUN;
            trial   <= RES_BITS'(1) << (RES_BITS - 1);
            bit_idx <= BW'(RES_BITS - 1);
            cyc     <= '0;
            eoc     <= 1'b0;
          end
        end
        SAR_RUN: begin
          if (cyc == KW'(CYC_PER_BIT - 1)) begin
            cyc <= '0;
            if (bit_idx == '0) begin
              result <= resolved;
              trial  <= resolved;
              state  <= SAR_IDLE;
              eoc    <= 1'b1;
            end else begin
              trial   <= resolved | (RES_BITS'(1) << (bit_idx - 1'b1));
              bit_idx <= bit_idx - 1'b1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: state <= SAR_IDLE;
      endcase
    end
  end

  // R7: a start request pulls eoc low on the next cycle
  a_r7_start_drops_eoc: assert property (@(posedge clk) disable iff (rst)
    start |=> !eoc);

  // R7: eoc stays low for the whole run
  a_r7_busy_eoc_low: assert property (@(posedge clk) disable iff (rst)
    (state == SAR_RUN) |-> !eoc);

  // R8: the search opens with exactly one trial bit set
  a_r8_first_trial: assert property (@(posedge clk) disable iff (rst)
    (state == SAR_IDLE && start) |=> $countones(trial) == 1);

  // R9: the stored result only changes at the end of a run
  a_r9_result_holds: assert property (@(posedge clk) disable iff (rst)
    (state == SAR_IDLE) |=> $stable(result));
endmodule

// File: rtl/adc_host_if.sv
`timescale 1ns/1ps
module adc_host_if #(
  parameter int RES_BITS    = 12,
  parameter int CMD_BITS    = 8,
  parameter int ADDR_BITS   = 4,
  parameter int CYC_PER_BIT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 io_clk,
  input  logic                 din,
  input  logic [RES_BITS-1:0]  ain_code,
  output logic                 dout,
  output logic                 dout_en,
  output logic                 sample_win,
  output logic                 eoc,
  output logic [ADDR_BITS-1:0] mux_addr,
  output logic [CMD_BITS-1:0]  cmd_word
);
  localparam logic [2:0] SYNC_RST = 3'b001;

  logic [2:0]          sync_lvl;
  logic                conv_start;
  logic                cmp_keep;
  logic [RES_BITS-1:0] trial;
  logic [RES_BITS-1:0] result;

  adc_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rst(rst),
    .async_in({din, io_clk, cs_n}),
    .lvl(sync_lvl)
  );

  adc_serial_port #(
    .RES_BITS(RES_BITS), .CMD_BITS(CMD_BITS), .ADDR_BITS(ADDR_BITS)
  ) u_port (
    .clk(clk), .rst(rst),
    .cs_act(~sync_lvl[0]),
    .io_lvl(sync_lvl[1]),
    .din_s(sync_lvl[2]),
    .prev_result(result),
    .mux_addr(mux_addr),
    .cmd_word(cmd_word),
    .sample_win(sample_win),
    .conv_start(conv_start),
    .dout(dout),
    .dout_en(dout_en)
  );

  adc_cmp_model #(.RES_BITS(RES_BITS)) u_cmp (
    .ain_code(ain_code), .trial(trial), .keep(cmp_keep)
  );

  adc_sar_engine #(
    .RES_BITS(RES_BITS), .CYC_PER_BIT(CYC_PER_BIT)
  ) u_sar (
    .clk(clk), .rst(rst),
    .start(conv_start),
    .cmp_keep(cmp_keep),
    .trial(trial),
    .result(result),
    .eoc(eoc)
  );
endmodule

// File: tb/adc_host_if_tb_top.sv
`timescale 1ns/1ps
module adc_host_if_tb_top;
  localparam int RES   = 12;
  localparam int CMDB  = 8;
  localparam int ADDRB = 4;
  localparam int HALF  = 8;
  localparam int NVEC  = 8;
  localparam logic [CMDB-1:0] CMDS [NVEC] =
    '{8'h00, 8'hF3, 8'h5C, 8'h5C, 8'hA0, 8'h1F, 8'hE6, 8'h70};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic io_clk = 1'b0;
  logic din = 1'b0;
  logic [RES-1:0]   ain_code;
  logic             dout, dout_en, sample_win, eoc;
  logic [ADDRB-1:0] mux_addr;
  logic [CMDB-1:0]  cmd_word;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [RES-1:0] lvl(input logic [ADDRB-1:0] c);
    logic [RES-1:0] t;
    if (c == '0) return '0;
    if (c == '1) return '1;
    t = {8'h00, c} * 12'h111;
    return t ^ 12'h05A;
  endfunction

  assign ain_code = lvl(mux_addr);

  adc_host_if dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .io_clk(io_clk), .din(din),
    .ain_code(ain_code), .dout(dout), .dout_en(dout_en),
    .sample_win(sample_win), .eoc(eoc), .mux_addr(mux_addr), .cmd_word(cmd_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [CMDB-1:0] cmd, input int nclk,
                           input logic [ADDRB-1:0] old_ch, output logic [RES-1:0] got);
    logic held;
    got = '0;
    cs_n = 1'b0;
    io_clk = 1'b0;
    wt(HALF);
    chk(dout_en == 1'b1, "R6 enable while selected", dout_en, 1);
    for (int k = 1; k <= nclk; k++) begin
      din = (k <= CMDB) ? cmd[CMDB-k] : k[0];
      wt(HALF);
      held = dout;
      got[RES-k] = dout;
      io_clk = 1'b1;
      wt(HALF);
      chk(dout == held, "R5 dout steady across rise", dout, held);
      if (k == 3) chk(mux_addr == old_ch, "R3 address held after rise 3", mux_addr, old_ch);
      if (k == 4) chk(mux_addr == cmd[7:4], "R3 address after rise 4", mux_addr, cmd[7:4]);
      io_clk = 1'b0;
      wt(HALF);
      chk(sample_win == (k >= 4 && k < RES), "R4 sample window", sample_win, (k >= 4 && k < RES));
    end
    cs_n = 1'b1;
    wt(HALF);
    chk(dout_en == 1'b0, "R6 released when deselected", dout_en, 0);
    chk(sample_win == 1'b0, "R4 window closed after frame", sample_win, 0);
  endtask

  task automatic wait_eoc(input int lo, input int hi);
    int n = 0;
    chk(eoc == 1'b0, "R7 eoc low after last fall", eoc, 0);
    while (!eoc && n < 400) begin
      wt(1);
      n++;
    end
    chk(eoc == 1'b1 && n >= lo && n <= hi, "R7 conversion length", n, 36);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RES-1:0]   got;
    logic [ADDRB-1:0] prev_ch;
    logic [RES-1:0]   exp_v;
    wt(2);
    chk(eoc == 1'b1 && dout_en == 1'b0 && sample_win == 1'b0, "R1 outputs during reset",
        {eoc, dout_en, sample_win}, 3'b100);
    wt(3);
    rst = 1'b0;
    wt(3);
    chk(eoc == 1'b1 && dout_en == 1'b0 && sample_win == 1'b0, "R1 outputs after reset",
        {eoc, dout_en, sample_win}, 3'b100);
    chk(mux_addr == '0 && cmd_word == '0, "R1 address and command cleared",
        {mux_addr, cmd_word}, 0);

    // Vector table: each frame returns the level of the channel asked for one frame earlier
    prev_ch = '0;
    for (int i = 0; i < NVEC; i++) begin
      run_frame(CMDS[i], RES, prev_ch, got);
      exp_v = (i == 0) ? '0 : lvl(CMDS[i-1][7:4]);
      if (i == 0) chk(got == exp_v, "R10 first frame after reset is zero", got, exp_v);
      else        chk(got == exp_v, "R8 result of previous channel via R5 order", got, exp_v);
      chk(cmd_word == CMDS[i], "R2 command byte, tail bits ignored", cmd_word, CMDS[i]);
      wait_eoc(30, 42);
      prev_ch = CMDS[i][7:4];
    end

    // R9: abort after six clocks
    run_frame(8'h90, 6, prev_ch, got);
    chk(eoc == 1'b1, "R9 no conversion after abort", eoc, 1);
    wt(60);
    chk(eoc == 1'b1, "R9 eoc stays high after abort", eoc, 1);
    chk(cmd_word == CMDS[NVEC-1], "R9 partial command discarded", cmd_word, CMDS[NVEC-1]);
    run_frame(8'h30, RES, 4'h9, got);
    exp_v = lvl(CMDS[NVEC-1][7:4]);
    chk(got == exp_v, "R9 result kept through abort", got, exp_v);
    wait_eoc(30, 42);
    run_frame(8'hF0, RES, 4'h3, got);
    exp_v = lvl(4'h3);
    chk(got == exp_v, "R8 result after aborted frame", got, exp_v);
    wait_eoc(30, 42);
    run_frame(8'h00, RES, 4'hF, got);
    chk(got == 12'hFFF, "R8 full-scale code", got, 12'hFFF);
    wait_eoc(30, 42);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule